// File: doc/BRIEF.md
# Software-Refilled Two-Way Address Translation Buffer

This block turns a 40-bit virtual address into a 36-bit physical address for 16 KB pages using a 512-entry, two-way set-associative table of translations. A lookup is combinational. It takes the address, a store flag and a user-mode flag. In the same cycle it returns exactly one of three outcomes: a hit with the physical address, a protection fault, or a miss trap that carries the faulting virtual page number.

The block never walks a page table. Privileged software fills entries through a write port that names the set, the way and the full entry contents. To pick a way to replace, software reads a per-set victim hint, which always names the way that was not hit most recently. A hit marks its entry as referenced, and a hit by a store also marks it dirty. Software can clear every reference bit at once to approximate least-recently-used replacement, and a single input drops every translation in one cycle.

Top module: `sw_refill_tlb`

## Requirements
- R1: On a hit, `pa` equals the entry's 22-bit physical page number followed by the unchanged low 14 bits of `va`.
- R2: The set is `va[21:14]` and the tag is `va[39:22]`. A lookup hits when a valid entry in either way of that set holds the tag. If both ways match, way 0 is used.
- R3: A requested lookup that matches no valid entry raises `miss_trap` and reports `va[39:14]` on `fault_vpn`. It changes no reference, dirty or victim state.
- R4: The rights field uses bit 0 for writable and bit 1 for user-accessible. A store to a non-writable entry, or a user-mode access to an entry without bit 1, raises `prot_fault` instead of a hit and changes no state.
- R5: Every hit sets the entry's reference bit. `ref_clear` clears all reference bits at the next edge. `hit_ref` shows the bit as it was before the hit.
- R6: A store hit sets the entry's dirty bit and a load hit leaves it unchanged. `hit_dirty` shows the bit as it was before the hit.
- R7: After a hit, the set's `victim_way` names the other way. `victim_way` shows the hint of the set addressed by `va`.
- R8: A write-port command takes effect at the next edge and not before. It loads the valid bit, dirty bit, rights, tag and physical page number, and it clears the entry's reference bit.
- R9: `flush_all` invalidates every entry at the next edge.
- R10: Synchronous reset clears every valid, reference, dirty and victim bit.
- R11: At most one of `hit`, `prot_fault` and `miss_trap` is high in a cycle, and all three are low when `req` is low. `pa`, `fault_vpn`, `hit_ref` and `hit_dirty` read zero when their outcome is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Lookup request |
| va | input | 40 | Virtual address |
| is_store | input | 1 | Access is a store |
| is_user | input | 1 | Access is made in user mode |
| hit | output | 1 | Translation found and access permitted |
| pa | output | 36 | Physical address |
| hit_ref | output | 1 | Reference bit of the hit entry |
| hit_dirty | output | 1 | Dirty bit of the hit entry |
| prot_fault | output | 1 | Entry found but access denied |
| miss_trap | output | 1 | No valid matching entry |
| fault_vpn | output | 26 | Virtual page number of a miss or fault |
| victim_way | output | 1 | Replacement hint for the addressed set |
| wr_en | input | 1 | Entry write strobe |
| wr_set | input | 8 | Set written |
| wr_way | input | 1 | Way written |
| wr_valid | input | 1 | Valid bit written |
| wr_dirty | input | 1 | Dirty bit written |
| wr_rights | input | 2 | Rights written (bit 0 writable, bit 1 user) |
| wr_tag | input | 18 | Tag written |
| wr_ppn | input | 22 | Physical page number written |
| ref_clear | input | 1 | Clear all reference bits |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The hardest case is a denied access that must leave no trace. That state shows only through a later permitted lookup of the same entry, which reports the reference and dirty bits as they stood before it. The stimulus loads entries with each restrictive rights code, makes the forbidden access, and then makes an allowed kernel access to the same address. Per-set independence is covered by a sweep that fills all 512 entries with distinct tags and page numbers. The sweep then hits every way, probes a missing tag in every set and follows the victim hint after each hit.

// File: rtl/sw_refill_tlb.sv
module sw_refill_tlb #(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int SET_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req,
  input  logic [VA_W-1:0]             va,
  input  logic                        is_store,
  input  logic                        is_user,
  output logic                        hit,
  output logic [PA_W-1:0]             pa,
  output logic                        hit_ref,
  output logic                        hit_dirty,
  output logic                        prot_fault,
  output logic                        miss_trap,
  output logic [VA_W-OFF_W-1:0]       fault_vpn,
  output logic                        victim_way,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic                        wr_way,
  input  logic                        wr_valid,
  input  logic                        wr_dirty,
  input  logic [1:0]                  wr_rights,
  input  logic [VA_W-OFF_W-SET_W-1:0] wr_tag,
  input  logic [PA_W-OFF_W-1:0]       wr_ppn,
  input  logic                        ref_clear,
  input  logic                        flush_all
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int ENT   = 2 * SETS;

  logic [ENT-1:0]   valid_q, ref_q, dirty_q;
  logic [SETS-1:0]  vict_q;
  logic [1:0]       rights_q [ENT];
  logic [TAG_W-1:0] tag_q    [ENT];
  logic [PPN_W-1:0] ppn_q    [ENT];

  wire [SET_W-1:0] set = va[OFF_W +: SET_W];
  wire [TAG_W-1:0] tag = va[VA_W-1 -: TAG_W];
  wire m0 = valid_q[{set, 1'b0}] && (tag_q[{set, 1'b0}] == tag);
  wire m1 = valid_q[{set, 1'b1}] && (tag_q[{set, 1'b1}] == tag);
  wire hw = !m0;
  wire [SET_W:0] hidx = {set, hw};
  wire [SET_W:0] widx = {wr_set, wr_way};
  wire [1:0] rt = rights_q[hidx];
  wire allow = !(is_store && !rt[0]) && !(is_user && !rt[1]);
  wire found = req && (m0 || m1);

  assign hit        = found && allow;
  assign prot_fault = found && !allow;
  assign miss_trap  = req && !(m0 || m1);
  assign pa         = hit ? {ppn_q[hidx], va[OFF_W-1:0]} : '0;
  assign hit_ref    = hit && ref_q[hidx];
  assign hit_dirty  = hit && dirty_q[hidx];
  assign fault_vpn  = (miss_trap || prot_fault) ? va[VA_W-1:OFF_W] : '0;
  assign victim_way = vict_q[set];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      vict_q  <= '0;
    end else begin
      if (hit && !(wr_en && widx == hidx)) begin
        ref_q[hidx] <= 1'b1;
        if (is_store) dirty_q[hidx] <= 1'b1;
        vict_q[set] <= !hw;
      end
      if (wr_en) begin
        valid_q[widx] <= wr_valid;
        ref_q[widx]   <= 1'b0;
        dirty_q[widx] <= wr_dirty;
      end
      if (ref_clear) ref_q <= '0;
      if (flush_all) valid_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      rights_q[widx] <= wr_rights;
      tag_q[widx]    <= wr_tag;
      ppn_q[widx]    <= wr_ppn;
    end
  end

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit, prot_fault, miss_trap}) && (req || !(hit || prot_fault || miss_trap)));

  // R3 and R4: a miss or a denied access leaves status untouched
  p_no_update_r3: assert property (@(posedge clk) disable iff (rst)
    (prot_fault || miss_trap) && !wr_en && !ref_clear |=>
      $stable(ref_q) && $stable(dirty_q) && $stable(vict_q));

  p_dirty_on_store_r6: assert property (@(posedge clk) disable iff (rst)
    hit && is_store && !wr_en |=> dirty_q[$past(hidx)]);

  p_victim_r7: assert property (@(posedge clk) disable iff (rst)
    hit && !wr_en |=> vict_q[$past(set)] == !$past(hw));

  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> valid_q == '0);
endmodule

// File: tb/sw_refill_tlb_test.sv
module sw_refill_tlb_test;
  logic clk = 0, rst = 1;
  logic req = 0, is_store = 0, is_user = 0;
  logic [39:0] va = '0;
  logic hit, hit_ref, hit_dirty, prot_fault, miss_trap, victim_way;
  logic [35:0] pa;
  logic [25:0] fault_vpn;
  logic wr_en = 0, wr_way = 0, wr_valid = 0, wr_dirty = 0, ref_clear = 0, flush_all = 0;
  logic [7:0] wr_set = '0;
  logic [1:0] wr_rights = '0;
  logic [17:0] wr_tag = '0;
  logic [21:0] wr_ppn = '0;
  int total = 0, fails = 0;

  always #4 clk = !clk;

  sw_refill_tlb uut (.*);

  function automatic logic [17:0] tag_of(int s, int w); return 18'(s * 2 + w + 1); endfunction
  function automatic logic [21:0] ppn_of(int s, int w); return 22'(s * 3 + w * 1000 + 7); endfunction
  function automatic logic [13:0] off_of(int s, int w); return 14'(s * 61 + w * 5); endfunction

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    req = 0; wr_en = 0; ref_clear = 0; flush_all = 0;
  endtask

  task automatic look(input logic [39:0] a, input logic st, input logic us);
    @(negedge clk);
    req = 1; va = a; is_store = st; is_user = us;
    #1;
  endtask

  task automatic put(input int s, input int w, input logic v, input logic d,
                     input logic [1:0] rr, input logic [17:0] t, input logic [21:0] p);
    @(negedge clk);
    wr_en = 1; wr_set = 8'(s); wr_way = 1'(w); wr_valid = v; wr_dirty = d;
    wr_rights = rr; wr_tag = t; wr_ppn = p;
    step();
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;

    look(40'h0, 0, 0);
    check("R10 miss after reset", miss_trap, 1);
    check("R10 victim after reset", victim_way, 0);
    check("R11 no hit after reset", hit, 0);
    step();

    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 2; w++)
        put(s, w, 1, 0, 2'b11, tag_of(s, w), ppn_of(s, w));

    for (int s = 0; s < 256; s++) begin
      for (int w = 0; w < 2; w++) begin
        look({tag_of(s, w), 8'(s), off_of(s, w)}, 0, 0);
        check("R2 hit", hit, 1);
        check("R1 pa", pa, {ppn_of(s, w), off_of(s, w)});
        step();
        check("R7 victim", victim_way, !w);
      end
      look({tag_of(s, 0) | 18'h20000, 8'(s), 14'h0}, 0, 0);
      check("R3 miss", miss_trap, 1);
      check("R3 vpn", fault_vpn, {tag_of(s, 0) | 18'h20000, 8'(s)});
      step();
    end

    // both ways hold the same tag: way 0 wins (R2)
    put(9, 1, 1, 0, 2'b11, tag_of(9, 0), 22'h3ABCD);
    look({tag_of(9, 0), 8'd9, 14'h5}, 0, 0);
    check("R2 way0 priority", pa, {ppn_of(9, 0), 14'h5});
    step();

    // no request: outputs quiet (R11)
    look({tag_of(3, 0), 8'd3, 14'h1}, 0, 0);
    req = 0; #1;
    check("R11 idle hit", {hit, miss_trap, prot_fault}, 0);
    check("R11 idle pa", pa, 0);
    step();

    // write visible only after the edge (R8)
    @(negedge clk);
    wr_en = 1; wr_set = 8'd20; wr_way = 0; wr_valid = 1; wr_dirty = 1;
    wr_rights = 2'b11; wr_tag = 18'h2AAAA; wr_ppn = 22'h12345;
    req = 1; va = {18'h2AAAA, 8'd20, 14'h77}; is_store = 0; is_user = 0; #1;
    check("R8 not before edge", miss_trap, 1);
    step();
    look({18'h2AAAA, 8'd20, 14'h77}, 0, 0);
    check("R8 hit after edge", hit, 1);
    check("R8 pa", pa, {22'h12345, 14'h77});
    check("R8 dirty loaded", hit_dirty, 1);
    check("R8 ref cleared", hit_ref, 0);
    step();
    look({18'h2AAAA, 8'd20, 14'h77}, 0, 0);
    check("R5 ref set by hit", hit_ref, 1);
    step();

    // protection: kernel read-only
    put(5, 0, 1, 0, 2'b00, 18'h11111, 22'h00AAA);
    look({18'h11111, 8'd5, 14'h0}, 0, 1);
    check("R4 user to kernel page", prot_fault, 1);
    check("R4 no hit", hit, 0);
    check("R4 fault vpn", fault_vpn, {18'h11111, 8'd5});
    step();
    look({18'h11111, 8'd5, 14'h0}, 1, 0);
    check("R4 store to read-only", prot_fault, 1);
    step();
    look({18'h11111, 8'd5, 14'h0}, 0, 0);
    check("R4 kernel load hits", hit, 1);
    check("R4 fault left ref clear", hit_ref, 0);
    check("R4 fault left dirty clear", hit_dirty, 0);
    step();
    // user read-only
    put(6, 1, 1, 0, 2'b10, 18'h22222, 22'h00BBB);
    look({18'h22222, 8'd6, 14'h0}, 1, 1);
    check("R4 user store read-only", prot_fault, 1);
    step();
    look({18'h22222, 8'd6, 14'h0}, 0, 1);
    check("R4 user load", hit, 1);
    check("R6 no dirty after fault", hit_dirty, 0);
    step();
    look({18'h22222, 8'd6, 14'h0}, 0, 0);
    check("R6 load keeps clean", hit_dirty, 0);
    step();
    // kernel writable
    put(7, 0, 1, 0, 2'b01, 18'h33333, 22'h00CCC);
    look({18'h33333, 8'd7, 14'h0}, 1, 1);
    check("R4 user store kernel page", prot_fault, 1);
    step();
    look({18'h33333, 8'd7, 14'h0}, 1, 0);
    check("R6 store hit", hit, 1);
    check("R6 dirty before", hit_dirty, 0);
    step();
    look({18'h33333, 8'd7, 14'h0}, 0, 0);
    check("R6 dirty after store", hit_dirty, 1);
    check("R5 ref after store", hit_ref, 1);
    step();

    // bulk reference clear (R5)
    @(negedge clk); ref_clear = 1; step();
    look({18'h33333, 8'd7, 14'h0}, 0, 0);
    check("R5 ref cleared", hit_ref, 0);
    check("R5 dirty kept", hit_dirty, 1);
    step();

    // flush (R9)
    @(negedge clk); flush_all = 1; step();
    look({18'h33333, 8'd7, 14'h0}, 0, 0);
    check("R9 flushed", miss_trap, 1);
    step();
    look({tag_of(200, 1), 8'd200, 14'h0}, 0, 0);
    check("R9 flushed other", miss_trap, 1);
    step();

    // reset clears valid and victim (R10)
    put(40, 1, 1, 0, 2'b11, 18'h01234, 22'h0F0F0);
    look({18'h01234, 8'd40, 14'h0}, 0, 0);
    check("R10 prep hit", hit, 1);
    step();
    check("R10 prep victim", victim_way, 0);
    put(40, 0, 1, 0, 2'b11, 18'h04321, 22'h0E0E0);
    look({18'h04321, 8'd40, 14'h0}, 0, 0);
    step();
    check("R7 victim after way0 hit", victim_way, 1);
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    look({18'h04321, 8'd40, 14'h0}, 0, 0);
    check("R10 valid cleared", miss_trap, 1);
    check("R10 victim cleared", victim_way, 0);
    step();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule